// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC datapath. It takes one data operand, a three-bit code that selects the kind of shift, a shift count and the current carry flag. In the same cycle it returns the shifted value and the carry that the shift produces. There are no registers inside. The surrounding pipeline stores the flag and feeds the carry-out to the flag-update logic, and the ALU consumes the shifted value.

The count comes either from an instruction immediate or from a register. A register can hold any value, so the block takes a full register-width count port and uses only its low byte. Within that byte it handles three cases apart from the normal one: a count of zero, a count equal to the data width, and a count larger than the data width. A fifth operation rotates right by one through the carry flag. That operation ignores the count.

Top module: `barrel_shifter`

## Requirements
- R1: Only bits [7:0] of `amount_i` affect the outputs. Two counts that agree in those bits give identical `result_o` and `carry_o`.
- R2: `kind_i` encodes: 0 shift left logical, 1 shift right logical, 2 shift right arithmetic, 3 rotate right, 4 rotate right by one through carry. Codes 5, 6 and 7 return the operand unchanged and set `carry_o` to `carry_i`.
- R3: For kinds 0 to 3, a count byte of zero returns the operand unchanged and sets `carry_o` to `carry_i`.
- R4: Shift left logical by n, with n from 1 to 32, returns the operand shifted left with zeros entering at bit 0. `carry_o` is operand bit (32 - n).
- R5: Shift left logical by more than 32 returns zero with `carry_o` = 0.
- R6: Shift right logical by n, with n from 1 to 32, returns the operand shifted right with zeros entering at bit 31. `carry_o` is operand bit (n - 1).
- R7: Shift right logical by more than 32 returns zero with `carry_o` = 0.
- R8: Shift right arithmetic by n, with n from 1 to 32, fills the vacated upper bits with operand bit 31. `carry_o` is operand bit (n - 1), so a count of 32 returns 32 copies of the sign with the sign as carry.
- R9: Shift right arithmetic by more than 32 returns all ones with `carry_o` = 1 for a negative operand, and zero with `carry_o` = 0 otherwise.
- R10: Rotate right by a nonzero count rotates by the count modulo 32, and `carry_o` equals bit 31 of the returned value. A nonzero multiple of 32 returns the operand with `carry_o` equal to operand bit 31.
- R11: Rotate right by one through carry returns {`carry_i`, operand[31:1]} with `carry_o` = operand bit 0, whatever the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH (32) | Data operand to shift |
| kind_i | input | 3 | Shift kind code (see R2) |
| amount_i | input | AMT_IN_W (32) | Shift count; only the low AMT_W (8) bits are used |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH (32) | Shifted value |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The bench builds the block with its default parameters: a 32-bit operand, a 32-bit count port and an 8-bit count field. With these values every count byte from 0 to 40, the boundary at exactly 32, a large count such as 255, and counts that differ only above bit 7 can all be applied. Each of those counts is swept over all eight kind codes, over operands with the sign bit set and clear, and over both carry-in values. Because the width is 32, the carry-bit positions and sign-fill rules can be compared against a plain 64-bit behavioural model.

// File: rtl/barrel_shifter_pkg.sv
// Package: barrel_shifter_pkg
// Purpose : shared shift-kind encoding for the barrel shifter and its checker.
// Assumes : kind codes are 3 bits wide; codes above RRX are unused.
package barrel_shifter_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/bsh_stage_net.sv
// Module : bsh_stage_net
// Purpose: logarithmic right-shift network. Stage k moves the data right by
//          2**k when bit k of the count is set. In rotate mode the bits that
//          leave at the bottom re-enter at the top; otherwise the fill bit enters.
// Assumes: WIDTH is a power of two and LOG_W = log2(WIDTH).
module bsh_stage_net #(
    parameter int WIDTH = 32,
    parameter int LOG_W = 5
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [LOG_W-1:0] sh_i,
    input  logic             rotate_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] lvl [0:LOG_W];

    // stage 0 input is the raw operand
    assign lvl[0] = data_i;

    genvar k;
    generate
        for (k = 0; k < LOG_W; k++) begin : g_stage
            localparam int S = 1 << k;
            logic [WIDTH-1:0] moved;
            // build the shifted or rotated version of this stage's input
            always_comb begin
                if (rotate_i) begin
                    moved = {lvl[k][S-1:0], lvl[k][WIDTH-1:S]};
                end else begin
                    moved = {{S{fill_i}}, lvl[k][WIDTH-1:S]};
                end
            end
            // take it only when the matching count bit is set
            assign lvl[k+1] = sh_i[k] ? moved : lvl[k];
        end
    endgenerate

    assign data_o = lvl[LOG_W];

endmodule

// File: rtl/bsh_carry_pick.sv
// Module : bsh_carry_pick
// Purpose: selects one operand bit as the shifter carry, addressed by a
//          count-width index, through a flat compare-and-select.
// Assumes: the index is below WIDTH whenever the result is used.
module bsh_carry_pick #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] idx_i,
    output logic             bit_o
);

    // one-hot compare per bit position, OR-combined
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (idx_i == AMT_W'(i)) begin
                bit_o = data_i[i];
            end
        end
    end

endmodule

// File: rtl/barrel_shifter.sv
// Module : barrel_shifter
// Purpose: combinational operand shifter with carry-out. It supports
//          left/right logical, right arithmetic, rotate right, and rotate
//          right by one through the carry flag.
// Assumes: WIDTH is a power of two below 2**AMT_W. The block has no state,
//          so no clock or reset is taken. Left shifts reuse the right-shift
//          network on a bit-reversed operand.
module barrel_shifter
    import barrel_shifter_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_IN_W = 32,
    parameter int AMT_W    = 8
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  logic [2:0]          kind_i,
    input  logic [AMT_IN_W-1:0] amount_i,
    input  logic                carry_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                carry_o
);

    localparam int                LOG_W     = $clog2(WIDTH);
    localparam logic [AMT_W-1:0]  WIDTH_AMT = AMT_W'(WIDTH);

    logic [AMT_W-1:0] amt;
    logic             unused_amt_hi;
    logic             is_left, is_right, is_rot, is_rrx;
    logic             amt_zero, amt_over, amt_big;
    logic             fill;
    logic [WIDTH-1:0] core_in, core_out, rev_in, rev_out;
    logic [AMT_W-1:0] pick_idx;
    logic             picked;

    // count field: only the low byte is used, the rest is ignored
    assign amt           = amount_i[AMT_W-1:0];
    assign unused_amt_hi = ^amount_i[AMT_IN_W-1:AMT_W];

    // kind decode
    assign is_left  = (kind_i == SK_LSL);
    assign is_right = (kind_i == SK_LSR) || (kind_i == SK_ASR);
    assign is_rot   = (kind_i == SK_ROR);
    assign is_rrx   = (kind_i == SK_RRX);

    // count range classification
    assign amt_zero = (amt == '0);
    assign amt_big  = (amt >= WIDTH_AMT);
    assign amt_over = (amt >  WIDTH_AMT);

    // arithmetic shifts fill with the sign, all others with zero
    assign fill = (kind_i == SK_ASR) ? opnd_i[WIDTH-1] : 1'b0;

    // bit reversal so the right-shift network also serves left shifts
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_rev
            assign rev_in[b]  = opnd_i[WIDTH-1-b];
            assign rev_out[b] = core_out[WIDTH-1-b];
        end
    endgenerate

    assign core_in = is_left ? rev_in : opnd_i;

    bsh_stage_net #(
        .WIDTH (WIDTH),
        .LOG_W (LOG_W)
    ) u_net (
        .data_i   (core_in),
        .sh_i     (amt[LOG_W-1:0]),
        .rotate_i (is_rot),
        .fill_i   (fill),
        .data_o   (core_out)
    );

    // carry index: bit (WIDTH - n) for left shifts, bit (n - 1) for right shifts
    assign pick_idx = is_left ? (WIDTH_AMT - amt) : (amt - AMT_W'(1));

    bsh_carry_pick #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_pick (
        .data_i (opnd_i),
        .idx_i  (pick_idx),
        .bit_o  (picked)
    );

    // final result and carry selection per kind and count range
    always_comb begin
        result_o = opnd_i;
        carry_o  = carry_i;
        if (is_rrx) begin
            result_o = {carry_i, opnd_i[WIDTH-1:1]};
            carry_o  = opnd_i[0];
        end else if (amt_zero) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else if (is_rot) begin
            result_o = core_out;
            carry_o  = core_out[WIDTH-1];
        end else if (is_left || is_right) begin
            if (amt_big) begin
                result_o = {WIDTH{fill}};
            end else begin
                result_o = is_left ? rev_out : core_out;
            end
            carry_o = amt_over ? fill : picked;
        end
    end

endmodule

// File: rtl/barrel_shifter_chk.sv
// Module : barrel_shifter_chk
// Purpose: port-level property checker for barrel_shifter, bound to every
//          instance. The block is combinational, so the checks are immediate
//          assertions evaluated whenever the ports change.
// Assumes: port names match the top module.
module barrel_shifter_chk
    import barrel_shifter_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_IN_W = 32,
    parameter int AMT_W    = 8
) (
    input logic [WIDTH-1:0]    opnd_i,
    input logic [2:0]          kind_i,
    input logic [AMT_IN_W-1:0] amount_i,
    input logic                carry_i,
    input logic [WIDTH-1:0]    result_o,
    input logic                carry_o
);

    logic [AMT_W-1:0] n;
    logic             known;
    logic             unused_chk_hi;

    assign n             = amount_i[AMT_W-1:0];
    assign unused_chk_hi = ^amount_i[AMT_IN_W-1:AMT_W];
    assign known         = !$isunknown({opnd_i, kind_i, n, carry_i});

    // port relations checked on every input change
    always_comb begin
        if (known) begin
            if (kind_i > SK_RRX)
                assert_unused_code_R2: assert (result_o == opnd_i && carry_o == carry_i);
            if (kind_i != SK_RRX && n == '0)
                assert_zero_count_R3: assert (result_o == opnd_i && carry_o == carry_i);
            if (kind_i == SK_LSL && n > AMT_W'(WIDTH))
                assert_lsl_over_R5: assert (result_o == '0 && carry_o == 1'b0);
            if (kind_i == SK_LSR && n > AMT_W'(WIDTH))
                assert_lsr_over_R7: assert (result_o == '0 && carry_o == 1'b0);
            if (kind_i == SK_ASR && n >= AMT_W'(WIDTH))
                assert_asr_sign_R9: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1]);
            if (kind_i == SK_ROR && n != '0)
                assert_ror_carry_R10: assert (carry_o == result_o[WIDTH-1] && $countones(result_o) == $countones(opnd_i));
            if (kind_i == SK_RRX)
                assert_rrx_R11: assert (result_o == {carry_i, opnd_i[WIDTH-1:1]} && carry_o == opnd_i[0]);
        end
    end

endmodule

bind barrel_shifter barrel_shifter_chk #(
    .WIDTH    (WIDTH),
    .AMT_IN_W (AMT_IN_W),
    .AMT_W    (AMT_W)
) u_chk (
    .opnd_i   (opnd_i),
    .kind_i   (kind_i),
    .amount_i (amount_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/barrel_shifter_tb.sv
`timescale 1ns/1ps
// Bench: barrel_shifter_tb
// Purpose: sweeps kinds, counts, operands and carry-in values through a
//          behavioural 64-bit reference model and compares on every clock.
module barrel_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [2:0]  kind_i = '0;
    logic [31:0] amount_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int applied = 0;
    int errors  = 0;
    bit done    = 0;

    // 125 MHz clock
    always #4 clk = ~clk;

    barrel_shifter u_dut (
        .opnd_i   (opnd_i),
        .kind_i   (kind_i),
        .amount_i (amount_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    // behavioural reference from the requirements
    task automatic model(input logic [31:0] x, input int k, input logic [31:0] a,
                         input logic ci, output logic [31:0] r, output logic c);
        int n;
        logic [63:0] t;
        n = int'(a[7:0]);
        r = x; c = ci;
        case (k)
            0: if (n > 32) begin r = 0; c = 0; end
               else if (n > 0) begin t = {32'b0, x} << n; r = t[31:0]; c = t[32]; end
            1: if (n > 32) begin r = 0; c = 0; end
               else if (n > 0) begin t = {x, 32'b0} >> n; r = t[63:32]; c = t[31]; end
            2: if (n > 32) begin r = {32{x[31]}}; c = x[31]; end
               else if (n > 0) begin t = 64'($signed({x, 32'b0}) >>> n); r = t[63:32]; c = t[31]; end
            3: if (n > 0) begin r = (x >> (n % 32)) | (x << (32 - (n % 32))); c = r[31]; end
            4: begin r = {ci, x[31:1]}; c = x[0]; end
            default: ;
        endcase
    endtask

    function automatic string tag(input int k, input logic [31:0] a);
        int n = int'(a[7:0]);
        if (a[31:8] != 0) return "R1";
        if (k > 4) return "R2";
        if (k == 4) return "R11";
        if (n == 0) return "R3";
        if (k == 3) return "R10";
        if (k == 0) return (n > 32) ? "R5" : "R4";
        if (k == 1) return (n > 32) ? "R7" : "R6";
        return (n > 32) ? "R9" : "R8";
    endfunction

    // drive after the rising edge, compare at the falling edge
    task automatic apply(input logic [31:0] x, input int k, input logic [31:0] a, input logic ci);
        logic [31:0] er;
        logic ec;
        @(posedge clk);
        #1;
        opnd_i = x; kind_i = 3'(k); amount_i = a; carry_i = ci;
        @(negedge clk);
        model(x, k, a, ci, er, ec);
        applied++;
        if (result_o !== er || carry_o !== ec) begin
            errors++;
            $display("FAIL %s kind=%0d amt=%h op=%h cin=%b: got %h/%b expected %h/%b",
                     tag(k, a), k, a, x, ci, result_o, carry_o, er, ec);
        end
    endtask

    logic [31:0] ops [4] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hFFFF_FFFF, 32'h0000_0000};

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R3: zero count pass-through right after reset
        apply(32'hDEAD_BEEF, 0, 32'd0, 1'b1);
        // R4 / R6 / R8 / R10 edge counts and R9 negative operand
        apply(32'h0000_0001, 0, 32'd32, 1'b0);
        apply(32'h8000_0000, 1, 32'd32, 1'b0);
        apply(32'h8000_0000, 2, 32'd33, 1'b0);
        apply(32'h8000_0000, 3, 32'd64, 1'b0);
        // R11: rotate through carry ignores the count
        apply(32'h0000_0003, 4, 32'd77, 1'b1);
        // full sweep: every kind code, counts 0..40 plus 255, both carries
        for (int k = 0; k < 8; k++) begin
            for (int o = 0; o < 4; o++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int n = 0; n <= 40; n++) apply(ops[o], k, 32'(n), ci[0]);
                    apply(ops[o], k, 32'd255, ci[0]);
                    // R1: upper count bits must be ignored
                    apply(ops[o], k, 32'hABCD_0105, ci[0]);
                    apply(ops[o], k, 32'h0000_1100, ci[0]);
                    apply(ops[o], k, 32'hFFFF_FF21, ci[0]);
                end
            end
        end
        done = 1;
    end

    // watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule